// File: doc/BRIEF.md
# Timer-Triggered Pulse Pattern Generator

This block drives a 16-bit group of output pins from an output data register whose contents change only when a timer compare-match pulse arrives. Software places the next pattern in a staging buffer. When the compare-match selected for a nibble of the output occurs, the buffer bits of that nibble are copied into the output data register. A stream of patterns can therefore be played out in step with a timer, provided software refills the staging buffer between events.

The 16 bits are split into four 4-bit groups. Each group picks one of four compare-match inputs through its own 2-bit select field. A pin is driven only when both its direction bit and its pulse-enable bit are set. Each pin can be inverted on its way out. Bits that are not pulse-enabled keep their output data value and remain writable by software.

The registers sit behind a simple single-cycle write port and a combinational read port.

Top module: `ppg_top`

## Requirements
- R1: After reset, every register (direction, pulse-enable, output data, staging buffer, trigger select, polarity) reads 0, and `pin_o` and `pin_oe_o` are 0.
- R2: `pin_oe_o[i]` is 1 exactly when direction bit i (address 0) and pulse-enable bit i (address 1) are both 1. A pin whose `pin_oe_o` bit is 0 is driven to 0.
- R3: A bus write to address 2 (output data) changes only the bits whose pulse-enable bit is 0. Before any trigger, a gated pin shows the value written there.
- R4: Trigger-select field g sits at bits [2g+1:2g] of address 4 and names the `trig_i` index for group g (bits [4g+3:4g]). A one-cycle pulse on that input copies the staging buffer (address 3) into the group's enabled output data bits at the next clock edge. With no pulse and no write, the output data does not change.
- R5: A pulse on a `trig_i` input that a group has not selected leaves that group's output data unchanged.
- R6: A trigger never changes output data bits whose pulse-enable bit is 0.
- R7: If the staging buffer is written in the same cycle as a trigger, the old buffer value is transferred and the newly written value is kept for the next trigger.
- R8: When polarity bit i (address 5) is 1, `pin_o[i]` is the inverse of output data bit i while the pin is gated on.
- R9: Successive triggers, with the buffer refilled between them, play successive patterns on the pins.
- R10: Addresses 0, 1, 2, 3 and 5 read back 16 bits. Address 4 reads back 8 bits, zero-extended. Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address for read and write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| trig_i | input | 4 | Compare-match pulses, one cycle wide |
| pin_o | output | 16 | Pulse output pattern after gating and polarity |
| pin_oe_o | output | 16 | Per-pin drive enable |

## Verification
The hardest case to reach from the ports is a staging-buffer write that lands on the same clock edge as a trigger. In that case the transferred value must come from before the write. The stimulus drives the write strobe and the compare-match pulse in the same half-cycle window. It then reads back both the output data and the buffer, and fires a second trigger to show the newly written value was kept. A second case is a mixed enable mask, where a trigger and software writes each reach only their own half of the bits. The bench builds this by loading output data before it sets the enables.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int GROUPS   = 4;
    localparam int GROUP_W  = 4;
    localparam int WIDTH    = GROUPS * GROUP_W;
    localparam int TRIGS    = 4;
    localparam int SEL_W    = $clog2(TRIGS);
    localparam int TSEL_W   = GROUPS * SEL_W;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR  = 3'd0,
        REG_ENA  = 3'd1,
        REG_ODAT = 3'd2,
        REG_NEXT = 3'd3,
        REG_TSEL = 3'd4,
        REG_POL  = 3'd5
    } ppg_reg_e;

    typedef struct packed {
        logic [WIDTH-1:0]  dir;
        logic [WIDTH-1:0]  ena;
        logic [WIDTH-1:0]  odat;
        logic [WIDTH-1:0]  nxt;
        logic [TSEL_W-1:0] tsel;
        logic [WIDTH-1:0]  pol;
    } ppg_regs_t;
endpackage

// File: rtl/ppg_trig_sel.sv
module ppg_trig_sel
    import ppg_pkg::*;
(
    input  logic [TRIGS-1:0]  trig_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic [WIDTH-1:0]  ena_i,
    output logic [WIDTH-1:0]  load_o
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [SEL_W-1:0] sel;
        logic             fire;

        assign sel  = tsel_i[g*SEL_W +: SEL_W];
        assign fire = trig_i[sel];
        assign load_o[g*GROUP_W +: GROUP_W] =
            {GROUP_W{fire}} & ena_i[g*GROUP_W +: GROUP_W];
    end
endmodule

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  load_i,
    output ppg_regs_t         regs_o,
    output logic [WIDTH-1:0]  rdata_o
);
    ppg_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // trigger transfer: load_i is already limited to enabled bits
        st_d.odat = (st_q.odat & ~load_i) | (st_q.nxt & load_i);
        if (wr_i) begin
            case (ppg_reg_e'(addr_i))
                REG_DIR:  st_d.dir  = wdata_i;
                REG_ENA:  st_d.ena  = wdata_i;
                REG_ODAT: st_d.odat = (st_d.odat & st_q.ena) | (wdata_i & ~st_q.ena);
                REG_NEXT: st_d.nxt  = wdata_i;
                REG_TSEL: st_d.tsel = wdata_i[TSEL_W-1:0];
                REG_POL:  st_d.pol  = wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (ppg_reg_e'(addr_i))
            REG_DIR:  rdata_o = st_q.dir;
            REG_ENA:  rdata_o = st_q.ena;
            REG_ODAT: rdata_o = st_q.odat;
            REG_NEXT: rdata_o = st_q.nxt;
            REG_TSEL: rdata_o = {{(WIDTH-TSEL_W){1'b0}}, st_q.tsel};
            REG_POL:  rdata_o = st_q.pol;
            default:  rdata_o = '0;
        endcase
    end

    assign regs_o = st_q;
endmodule

// File: rtl/ppg_out_stage.sv
module ppg_out_stage
    import ppg_pkg::*;
(
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] ena_i,
    input  logic [WIDTH-1:0] odat_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] pin_o,
    output logic [WIDTH-1:0] oe_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic gate;
        assign gate     = dir_i[i] & ena_i[i];
        assign oe_o[i]  = gate;
        assign pin_o[i] = gate & (odat_i[i] ^ pol_i[i]);
    end
endmodule

// File: rtl/ppg_top.sv
module ppg_top
    import ppg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [TRIGS-1:0]  trig_i,
    output logic [WIDTH-1:0]  pin_o,
    output logic [WIDTH-1:0]  pin_oe_o
);
    ppg_regs_t        regs;
    logic [WIDTH-1:0] load_mask;
    logic [WIDTH-1:0] odat_w, nxt_w, ena_w;

    assign odat_w = regs.odat;
    assign nxt_w  = regs.nxt;
    assign ena_w  = regs.ena;

    ppg_trig_sel u_trig (
        .trig_i (trig_i),
        .tsel_i (regs.tsel),
        .ena_i  (regs.ena),
        .load_o (load_mask)
    );

    ppg_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .load_i  (load_mask),
        .regs_o  (regs),
        .rdata_o (bus_rdata_o)
    );

    ppg_out_stage u_out (
        .dir_i  (regs.dir),
        .ena_i  (regs.ena),
        .odat_i (regs.odat),
        .pol_i  (regs.pol),
        .pin_o  (pin_o),
        .oe_o   (pin_oe_o)
    );
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker
    import ppg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [TRIGS-1:0]  trig,
    input logic [WIDTH-1:0]  pin,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  odat,
    input logic [WIDTH-1:0]  nxt,
    input logic [WIDTH-1:0]  ena,
    input logic [WIDTH-1:0]  ld_mask
);
    assert_idle_pin_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin & ~pin_oe) == '0);

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && trig == '0) |=> $stable(odat));

    assert_load_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig != '0) |=> ((odat & $past(ld_mask)) == ($past(nxt) & $past(ld_mask))));

    assert_disabled_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr) |=> ((odat & ~$past(ena)) == ($past(odat) & ~$past(ena))));

    assert_buf_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_NEXT) |=> (nxt == $past(bus_wdata)));
endmodule

bind ppg_top ppg_checker u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .trig      (trig_i),
    .pin       (pin_o),
    .pin_oe    (pin_oe_o),
    .odat      (odat_w),
    .nxt       (nxt_w),
    .ena       (ena_w),
    .ld_mask   (load_mask)
);

// File: tb/ppg_top_tb.sv
module ppg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  trig = '0;
    logic [15:0] pin, oe;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ppg_top u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .trig_i(trig),
        .pin_o(pin), .pin_oe_o(oe)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr = 1'b0; trig = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wreg(logic [2:0] a, logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic pulse(logic [3:0] t);
        @(negedge clk); trig = t;
        @(negedge clk); trig = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        for (int a = 0; a < 6; a++) begin
            rreg(3'(a), d);
            chk("R1 reg clear", d, 16'h0000);
        end
        chk("R1 pin", pin, 16'h0000);
        chk("R1 oe", oe, 16'h0000);
    endtask

    task automatic t_gating();
        do_reset();
        wreg(3'd2, 16'hFFFF);
        wreg(3'd0, 16'h00FF);
        wreg(3'd1, 16'h0F0F);
        #1;
        chk("R2 oe", oe, 16'h000F);
        chk("R2 pin", pin, 16'h000F);
    endtask

    task automatic t_initial();
        logic [15:0] d;
        do_reset();
        wreg(3'd2, 16'hC3A5);
        wreg(3'd0, 16'hFFFF);
        wreg(3'd1, 16'h00FF);
        #1;
        chk("R3 initial pin", pin, 16'h00A5);
        wreg(3'd2, 16'h5A5A);
        rreg(3'd2, d);
        chk("R3 masked write", d, 16'h5AA5);
    endtask

    task automatic t_trigger();
        logic [15:0] d;
        do_reset();
        wreg(3'd4, 16'h00AA);
        wreg(3'd0, 16'hFFFF);
        wreg(3'd1, 16'hFFFF);
        wreg(3'd3, 16'h5A3C);
        #1;
        chk("R4 no trigger yet", pin, 16'h0000);
        pulse(4'b0100);
        rreg(3'd2, d);
        chk("R4 odat after trigger", d, 16'h5A3C);
        chk("R4 pins after trigger", pin, 16'h5A3C);
        wreg(3'd3, 16'h1234);
        pulse(4'b1011);
        rreg(3'd2, d);
        chk("R5 unselected inputs", d, 16'h5A3C);
    endtask

    task automatic t_groups();
        logic [15:0] d;
        do_reset();
        wreg(3'd4, 16'h00E4);
        wreg(3'd1, 16'hFFFF);
        wreg(3'd3, 16'hFFFF);
        pulse(4'b0010);
        rreg(3'd2, d);
        chk("R5 group1 only", d, 16'h00F0);
        pulse(4'b1000);
        rreg(3'd2, d);
        chk("R5 group3 added", d, 16'hF0F0);
    endtask

    task automatic t_disabled();
        logic [15:0] d;
        do_reset();
        wreg(3'd2, 16'hA005);
        wreg(3'd1, 16'h0FF0);
        wreg(3'd3, 16'hFFFF);
        pulse(4'b0001);
        rreg(3'd2, d);
        chk("R6 disabled bits kept", d, 16'hAFF5);
    endtask

    task automatic t_same_cycle();
        logic [15:0] d;
        do_reset();
        wreg(3'd1, 16'hFFFF);
        wreg(3'd3, 16'h1111);
        @(negedge clk); wr = 1'b1; addr = 3'd3; wdata = 16'h2222; trig = 4'b0001;
        @(negedge clk); wr = 1'b0; trig = '0;
        rreg(3'd2, d);
        chk("R7 old buffer moved", d, 16'h1111);
        rreg(3'd3, d);
        chk("R7 new buffer kept", d, 16'h2222);
        pulse(4'b0001);
        rreg(3'd2, d);
        chk("R7 next trigger", d, 16'h2222);
    endtask

    task automatic t_polarity();
        do_reset();
        wreg(3'd5, 16'h00FF);
        wreg(3'd2, 16'h0F0F);
        wreg(3'd0, 16'hFFFF);
        wreg(3'd1, 16'hFFFF);
        #1;
        chk("R8 inverted pins", pin, 16'h0FF0);
    endtask

    task automatic t_sequence();
        logic [15:0] pats [4] = '{16'h8001, 16'h4002, 16'h2004, 16'h1008};
        do_reset();
        wreg(3'd4, 16'h00FF);
        wreg(3'd0, 16'hFFFF);
        wreg(3'd1, 16'hFFFF);
        for (int k = 0; k < 4; k++) begin
            wreg(3'd3, pats[k]);
            pulse(4'b1000);
            #1;
            chk("R9 sequence step", pin, pats[k]);
        end
    endtask

    task automatic t_readback();
        logic [15:0] d;
        do_reset();
        wreg(3'd0, 16'h1357);
        wreg(3'd2, 16'h2468);
        wreg(3'd1, 16'h9BDF);
        wreg(3'd3, 16'hACE0);
        wreg(3'd4, 16'hFFFF);
        wreg(3'd5, 16'h7777);
        wreg(3'd6, 16'hFFFF);
        wreg(3'd7, 16'hFFFF);
        rreg(3'd0, d); chk("R10 dir", d, 16'h1357);
        rreg(3'd1, d); chk("R10 ena", d, 16'h9BDF);
        rreg(3'd2, d); chk("R10 odat", d, 16'h2468);
        rreg(3'd3, d); chk("R10 next", d, 16'hACE0);
        rreg(3'd4, d); chk("R10 tsel width", d, 16'h00FF);
        rreg(3'd5, d); chk("R10 pol", d, 16'h7777);
        rreg(3'd6, d); chk("R10 unmapped 6", d, 16'h0000);
        rreg(3'd7, d); chk("R10 unmapped 7", d, 16'h0000);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_gating();
        t_initial();
        t_trigger();
        t_groups();
        t_disabled();
        t_same_cycle();
        t_polarity();
        t_sequence();
        t_readback();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule